// File: doc/BRIEF.md
# Triple Readback Comparison Monitor

This block supervises three identical logic devices that hold the same configuration and run in lockstep. Each device streams its configuration readback serially. Upstream logic packs the streams into words of `DATA_W` bits and presents one word from each device together with a valid strobe. The monitor compares the three words on every valid cycle. It works out whether all three agree, whether exactly one device is the odd one out, or whether the three words are pairwise different.

When a single device disagrees, the monitor raises a one-cycle reconfiguration request for that device only, and the other two keep running. The request stays armed-off for that device until the reconfiguration logic reports completion. A saturating counter for each device records how many requests were issued. Frame start and end markers bound a readback pass. A clean-pass pulse reports a frame in which no valid word showed any disagreement.

Checking never stalls: a new word can be accepted on every clock cycle, and the block has no handshake back to the streams.

Top module: `tmr_readback_monitor`

## Requirements
- R1: In the cycle after a valid word on which all three inputs are equal, `agree_o` pulses high for one cycle, and no request or `uncorr_o` is raised for that word.
- R2: When exactly one device's word differs and the other two are equal, `reconf_req_o[d]` pulses for one cycle in the next cycle, where bit index d equals the device index (0, 1, 2 for `rb_word0_i`, `rb_word1_i`, `rb_word2_i`). No other request bit is set.
- R3: Each issued request adds one to that device's counter, found at `upset_cnt_o[d*CNT_W +: CNT_W]`, in the same cycle the request pulse appears. The counter holds at all ones once it gets there.
- R4: After a request for device d, further odd-one-out words blaming d raise no request and leave its counter unchanged, until `reconf_done_i[d]` is seen. A mismatch in the same cycle as that done is also ignored.
- R5: A high `reconf_done_i[d]` re-arms device d, so the next word blaming d raises a new request.
- R6: A valid word on which all three inputs are pairwise different pulses `uncorr_o` in the next cycle, issues no request, and changes no counter.
- R7: `clean_pass_o` pulses in the cycle after `frame_end_i` when a frame start was seen since the previous end, or in the same cycle as the end, and every valid word since that start was in full agreement. The word presented with the end marker is included.
- R8: `frame_start_i` discards the disagreement history of earlier words. A valid word presented with the start marker belongs to the new frame.
- R9: While `bit_vld_i` is low, the word inputs have no effect on any output.
- R10: After reset all outputs are zero, including every counter.
- R11: Valid words on consecutive cycles are each judged, with no gaps or stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | The three readback words are valid this cycle |
| rb_word0_i | input | DATA_W | Readback word from device 0 |
| rb_word1_i | input | DATA_W | Readback word from device 1 |
| rb_word2_i | input | DATA_W | Readback word from device 2 |
| frame_start_i | input | 1 | Start of a readback pass |
| frame_end_i | input | 1 | End of a readback pass |
| reconf_done_i | input | 3 | Reconfiguration of device d has finished (bit d) |
| reconf_req_o | output | 3 | One-cycle request to reconfigure device d (bit d) |
| agree_o | output | 1 | Pulse: last valid word agreed on all three devices |
| uncorr_o | output | 1 | Pulse: last valid word was pairwise different |
| clean_pass_o | output | 1 | Pulse: frame ended with no disagreement |
| upset_cnt_o | output | 3*CNT_W | Saturating request counters, device d in field d |

## Verification
On every cycle the assertions check these properties: requests are single-cycle pulses and never name more than one device, the agree, uncorrectable and request outputs exclude one another, a clean pass never coincides with a disagreement report, and each counter only ever holds its value or rises by one. Only the bench scenarios can show that the right device is blamed, that a pending request suppresses further requests until completion arrives, that counters saturate, and that frame markers bound the clean-pass decision, including the words presented in the same cycle as a marker.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int NUM_DEV = 3;

  typedef struct packed {
    logic               agree;
    logic               uncorr;
    logic [NUM_DEV-1:0] odd;
  } verdict_t;
endpackage

// File: rtl/rbm_vote.sv
module rbm_vote
  import rbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              vld_i,
  input  logic [DATA_W-1:0] word0_i,
  input  logic [DATA_W-1:0] word1_i,
  input  logic [DATA_W-1:0] word2_i,
  output verdict_t          verdict_o
);
  logic eq01, eq02, eq12;

  always_comb begin
    eq01 = (word0_i == word1_i);
    eq02 = (word0_i == word2_i);
    eq12 = (word1_i == word2_i);
    verdict_o.agree  = vld_i & eq01 & eq12;
    verdict_o.uncorr = vld_i & ~eq01 & ~eq02 & ~eq12;
    // the device outside the only equal pair is the odd one
    verdict_o.odd[0] = vld_i & eq12 & ~eq01;
    verdict_o.odd[1] = vld_i & eq02 & ~eq01;
    verdict_o.odd[2] = vld_i & eq01 & ~eq02;
  end
endmodule

// File: rtl/rbm_dev_track.sv
module rbm_dev_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             odd_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pend_q, pend_d;
  logic             req_q, req_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire;
  logic             en;

  always_comb begin
    fire   = odd_i & ~pend_q;
    req_d  = fire;
    pend_d = pend_q;
    if (fire)        pend_d = 1'b1;
    else if (done_i) pend_d = 1'b0;
    cnt_d = cnt_q;
    if (fire && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    en = fire | done_i | req_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      req_q  <= req_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o = req_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rbm_frame.sv
module rbm_frame (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic mis_i,
  output logic clean_o
);
  logic in_q, in_d;
  logic dirty_q, dirty_d;
  logic clean_q, clean_d;
  logic open_now;
  logic dirty_now;

  always_comb begin
    open_now  = start_i | in_q;
    dirty_now = start_i ? mis_i : (dirty_q | mis_i);
    clean_d   = end_i & open_now & ~dirty_now;
    dirty_d   = dirty_now;
    in_d      = in_q;
    if (start_i) in_d = 1'b1;
    if (end_i)   in_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= 1'b0;
      dirty_q <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      in_q    <= in_d;
      dirty_q <= dirty_d;
      clean_q <= clean_d;
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/tmr_readback_monitor.sv
module tmr_readback_monitor
  import rbm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bit_vld_i,
  input  logic [DATA_W-1:0]          rb_word0_i,
  input  logic [DATA_W-1:0]          rb_word1_i,
  input  logic [DATA_W-1:0]          rb_word2_i,
  input  logic                       frame_start_i,
  input  logic                       frame_end_i,
  input  logic [NUM_DEV-1:0]         reconf_done_i,
  output logic [NUM_DEV-1:0]         reconf_req_o,
  output logic                       agree_o,
  output logic                       uncorr_o,
  output logic                       clean_pass_o,
  output logic [NUM_DEV*CNT_W-1:0]   upset_cnt_o
);
  verdict_t verdict;
  logic     mis_now;
  logic     agree_q, uncorr_q;

  rbm_vote #(.DATA_W(DATA_W)) u_vote (
    .vld_i    (bit_vld_i),
    .word0_i  (rb_word0_i),
    .word1_i  (rb_word1_i),
    .word2_i  (rb_word2_i),
    .verdict_o(verdict)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    rbm_dev_track #(.CNT_W(CNT_W)) u_trk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .odd_i (verdict.odd[d]),
      .done_i(reconf_done_i[d]),
      .req_o (reconf_req_o[d]),
      .cnt_o (upset_cnt_o[d*CNT_W +: CNT_W])
    );
  end

  assign mis_now = bit_vld_i & ~verdict.agree;

  rbm_frame u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frame_start_i),
    .end_i  (frame_end_i),
    .mis_i  (mis_now),
    .clean_o(clean_pass_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agree_q  <= 1'b0;
      uncorr_q <= 1'b0;
    end else begin
      agree_q  <= verdict.agree;
      uncorr_q <= verdict.uncorr;
    end
  end

  assign agree_o  = agree_q;
  assign uncorr_o = uncorr_q;
endmodule

// File: rtl/rbm_chk.sv
module rbm_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         reconf_req_o,
  input logic               agree_o,
  input logic               uncorr_o,
  input logic               clean_pass_o,
  input logic [3*CNT_W-1:0] upset_cnt_o
);
  // R2
  one_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reconf_req_o));

  // R2
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reconf_req_o != 3'b000) |=> ((reconf_req_o & $past(reconf_req_o)) == 3'b000));

  // R6
  uncorr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> (reconf_req_o == 3'b000 && !agree_o));

  // R1
  agree_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agree_o |-> (reconf_req_o == 3'b000));

  // R7
  clean_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_pass_o |-> (!uncorr_o && reconf_req_o == 3'b000));

  for (genvar d = 0; d < 3; d++) begin : g_cnt
    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upset_cnt_o[d*CNT_W +: CNT_W] == $past(upset_cnt_o[d*CNT_W +: CNT_W])) ||
      (upset_cnt_o[d*CNT_W +: CNT_W] == $past(upset_cnt_o[d*CNT_W +: CNT_W]) + 1'b1));
  end
endmodule

bind tmr_readback_monitor rbm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reconf_req_o(reconf_req_o),
  .agree_o     (agree_o),
  .uncorr_o    (uncorr_o),
  .clean_pass_o(clean_pass_o),
  .upset_cnt_o (upset_cnt_o)
);

// File: tb/tmr_readback_monitor_test.sv
module tmr_readback_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld;
  logic [DW-1:0] w0, w1, w2;
  logic          fs, fe;
  logic [2:0]    done;
  logic [2:0]    req;
  logic          agree, uncorr, clean;
  logic [3*CW-1:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_readback_monitor #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld),
    .rb_word0_i(w0), .rb_word1_i(w1), .rb_word2_i(w2),
    .frame_start_i(fs), .frame_end_i(fe), .reconf_done_i(done),
    .reconf_req_o(req), .agree_o(agree), .uncorr_o(uncorr),
    .clean_pass_o(clean), .upset_cnt_o(cnt)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cnt_of(int d);
    return cnt[d*CW +: CW];
  endfunction

  task automatic idle();
    vld = 0; w0 = '0; w1 = '0; w2 = '0; fs = 0; fe = 0; done = '0;
  endtask

  // drive one cycle at negedge, release at next negedge: outputs then show the result
  task automatic step(logic v, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c,
                      logic s, logic e, logic [2:0] dn);
    vld = v; w0 = a; w1 = b; w2 = c; fs = s; fe = e; done = dn;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    check("R10 req", {29'd0, req}, 0);
    check("R10 flags", {29'd0, agree, uncorr, clean}, 0);
    check("R10 cnt", {20'd0, cnt}, 0);
  endtask

  task automatic t_agree();
    step(1, 8'h3C, 8'h3C, 8'h3C, 0, 0, 0);
    check("R1 agree", {31'd0, agree}, 1);
    check("R1 no req", {29'd0, req}, 0);
    @(negedge clk);
    check("R1 one cycle", {31'd0, agree}, 0);
  endtask

  task automatic t_single();
    step(1, 8'hA5, 8'h11, 8'h11, 0, 0, 0);
    check("R2 dev0", {29'd0, req}, 3'b001);
    check("R3 cnt0", {28'd0, cnt_of(0)}, 1);
    @(negedge clk);
    check("R2 pulse", {29'd0, req}, 0);
    step(1, 8'h22, 8'h01, 8'h22, 0, 0, 0);
    check("R2 dev1", {29'd0, req}, 3'b010);
    step(1, 8'h44, 8'h44, 8'hFF, 0, 0, 0);
    check("R2 dev2", {29'd0, req}, 3'b100);
    check("R3 cnts", {20'd0, cnt}, {4'd1, 4'd1, 4'd1});
  endtask

  task automatic t_pending();
    step(1, 8'h00, 8'h55, 8'h55, 0, 0, 0);
    check("R4 ignored", {29'd0, req}, 0);
    check("R4 cnt held", {28'd0, cnt_of(0)}, 1);
    // mismatch alongside done is still ignored
    step(1, 8'h00, 8'h55, 8'h55, 0, 0, 3'b001);
    check("R4 same cycle done", {29'd0, req}, 0);
    step(1, 8'h00, 8'h55, 8'h55, 0, 0, 0);
    check("R5 rearmed", {29'd0, req}, 3'b001);
    check("R5 cnt0", {28'd0, cnt_of(0)}, 2);
    step(0, 0, 0, 0, 0, 0, 3'b111);
  endtask

  task automatic t_uncorr();
    step(1, 8'h01, 8'h02, 8'h04, 0, 0, 0);
    check("R6 uncorr", {31'd0, uncorr}, 1);
    check("R6 no req", {29'd0, req}, 0);
    check("R6 cnt", {20'd0, cnt}, {4'd1, 4'd1, 4'd2});
  endtask

  task automatic t_invalid();
    step(0, 8'h01, 8'h02, 8'h02, 0, 0, 0);
    check("R9 no req", {29'd0, req}, 0);
    check("R9 no flags", {29'd0, agree, uncorr, clean}, 0);
    check("R9 cnt", {20'd0, cnt}, {4'd1, 4'd1, 4'd2});
  endtask

  task automatic t_back_to_back();
    vld = 1; w0 = 8'h7; w1 = 8'h7; w2 = 8'h7;
    @(negedge clk);
    check("R11 word a", {31'd0, agree}, 1);
    w0 = 8'h1; w1 = 8'h2; w2 = 8'h3;
    @(negedge clk);
    check("R11 word b", {31'd0, uncorr}, 1);
    w0 = 8'h9; w1 = 8'h9; w2 = 8'h9;
    @(negedge clk);
    idle();
    check("R11 word c", {30'd0, agree, uncorr}, 2'b10);
  endtask

  task automatic t_frames();
    step(1, 8'h5, 8'h5, 8'h5, 1, 0, 0);
    step(1, 8'h6, 8'h6, 8'h6, 0, 0, 0);
    step(1, 8'h8, 8'h8, 8'h8, 0, 1, 0);
    check("R7 clean", {31'd0, clean}, 1);
    @(negedge clk);
    check("R7 one cycle", {31'd0, clean}, 0);
    step(1, 8'h5, 8'h5, 8'h5, 1, 0, 0);
    step(1, 8'h1, 8'h2, 8'h3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R7 dirty frame", {31'd0, clean}, 0);
    // mismatch carried on the end word
    step(1, 8'h5, 8'h5, 8'h5, 1, 0, 0);
    step(1, 8'h1, 8'h2, 8'h3, 0, 1, 0);
    check("R7 end word counts", {31'd0, clean}, 0);
    // history before start is dropped
    step(1, 8'h1, 8'h2, 8'h3, 0, 0, 0);
    step(1, 8'hC, 8'hC, 8'hC, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R8 restart", {31'd0, clean}, 1);
    // start word belongs to new frame
    step(1, 8'h1, 8'h2, 8'h3, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R8 start word", {31'd0, clean}, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R7 no open frame", {31'd0, clean}, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) begin
      step(1, 8'h3, 8'h3, 8'h4, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 3'b100);
    end
    check("R3 saturate", {28'd0, cnt_of(2)}, 15);
    check("R3 others", {24'd0, cnt_of(1), cnt_of(0)}, {4'd1, 4'd2});
    step(1, 8'h3, 8'h3, 8'h4, 0, 0, 0);
    check("R3 req at max", {29'd0, req}, 3'b100);
    check("R3 held at max", {28'd0, cnt_of(2)}, 15);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_agree();
    t_single();
    t_pending();
    t_uncorr();
    t_invalid();
    t_back_to_back();
    t_frames();
    t_saturate();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule